// File: doc/BRIEF.md
# Compressed DFA Walker with Default Links

This block scans a byte stream against a deterministic automaton whose tables live in on-chip registers. Each byte is first reduced to a small symbol class through a 256-entry translation table, so that characters that behave identically (for example upper and lower case of one letter, or every character that no rule uses) share a single class. Each state then stores only the few transitions that differ from its fallback, as (class, next-state) pairs in a flat transition memory, plus one default pointer. A default link consumes no input.

When the current state has no labelled transition for the byte's class, the walker moves along the default link and searches again with the same class. Default links point back toward the start state. The walk therefore always ends either at a state with a labelled hit or at the root. The input stalls while such a chain is followed. When the byte is finally resolved, the block reports whether it entered an accepting state and, if so, which rule. The tables are written through a load port whenever no scan is in progress. A bound on the chain length stops a corrupted table from hanging the walker.

Top module: `dfa_walker`

## Requirements
- R1: Synchronous active-high reset puts the walker in state 0 with `in_ready` high and `err_chain` low. Table contents are not cleared by reset.
- R2: Every byte is mapped through the class table before lookup. A byte loaded with class 0 is treated like any byte that no rule uses, and two bytes loaded with the same class behave identically.
- R3: A byte whose class has a labelled transition in the current state is resolved in its handshake cycle: `out_valid` is high in that cycle and `in_ready` stays high in the next one.
- R4: A byte with no labelled transition in a non-root state makes the walker follow the default pointer without consuming the byte. `in_ready` is low while the chain is followed, and the byte resolves one cycle after each default hop.
- R5: A byte with no labelled transition in state 0 is consumed, and the walker stays in state 0.
- R6: `out_match` is high, and `out_rule` carries the rule id of the state entered, only in an `out_valid` cycle in which that state is accepting. Otherwise `out_rule` is 0.
- R7: If a byte still misses after CHAIN_MAX default hops, the byte is dropped with `out_valid` high and `out_match` low, the walker returns to state 0, and `err_chain` goes high and stays high until reset.
- R8: A load (`ld_en`) takes effect only in a cycle in which the walker is not following a chain and `in_valid` is low; otherwise it is ignored. `ld_sel` 0 writes the class table (class in the low `ld_data` bits), 1 writes a state entry, 2 writes a transition entry.
- R9: Exactly one `out_valid` pulse is produced for each byte accepted by the handshake. `out_valid` appears only while that byte is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Walker can take a byte (low during a default chain) |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | One pulse per resolved byte |
| out_match | output | 1 | Resolved byte entered an accepting state |
| out_rule | output | RULE_W (4) | Rule id of the accepting state, else 0 |
| err_chain | output | 1 | Sticky: default chain exceeded CHAIN_MAX |
| ld_en | input | 1 | Table write request |
| ld_sel | input | 2 | Target: 0 class table, 1 state table, 2 transition memory |
| ld_addr | input | 8 | Entry index within the selected table |
| ld_data | input | LD_W (17) | Entry contents (packed state or transition entry, or class) |

## Verification
The hardest condition to reach from the ports is the chain-length overflow, because any well-formed table only ever walks backward and always terminates. The stimulus reaches it by first running normal traffic. It then rewrites the tables: a new labelled transition is added from the root into a fresh state whose default link points to itself, and a byte is steered into that state. The next byte then spins until the bound trips. The ignored-load case is reached in the same way. A byte that forces a default hop is sent, and a class-table write is presented in the cycle in which `in_ready` has dropped.

// File: rtl/dfa_walk_pkg.sv
package dfa_walk_pkg;

    localparam int BYTE_W  = 8;
    localparam int CLASS_W = 3;
    localparam int STATE_W = 4;
    localparam int TIDX_W  = 5;
    localparam int CNT_W   = 3;
    localparam int RULE_W  = 4;
    localparam int MAX_LBL = 4;

    localparam int N_BYTES  = 1 << BYTE_W;
    localparam int N_STATES = 1 << STATE_W;
    localparam int N_TRANS  = 1 << TIDX_W;

    typedef struct packed {
        logic [TIDX_W-1:0]  base;
        logic [CNT_W-1:0]   cnt;
        logic [STATE_W-1:0] dflt;
        logic               acc;
        logic [RULE_W-1:0]  rule;
    } state_ent_t;

    typedef struct packed {
        logic [CLASS_W-1:0] cls;
        logic [STATE_W-1:0] nxt;
    } trans_ent_t;

    localparam int LD_W = $bits(state_ent_t);

    typedef enum logic [1:0] {
        LD_CLASS = 2'd0,
        LD_STATE = 2'd1,
        LD_TRANS = 2'd2
    } ld_sel_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WALK = 1'b1
    } phase_t;

endpackage

// File: rtl/dfa_class_map.sv
module dfa_class_map
    import dfa_walk_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [BYTE_W-1:0]  waddr,
    input  logic [CLASS_W-1:0] wcls,
    input  logic [BYTE_W-1:0]  rbyte,
    output logic [CLASS_W-1:0] rcls
);
    logic [CLASS_W-1:0] tbl [N_BYTES];

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wcls;
    end

    assign rcls = tbl[rbyte];
endmodule

// File: rtl/dfa_state_table.sv
module dfa_state_table
    import dfa_walk_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [STATE_W-1:0] waddr,
    input  state_ent_t         wdata,
    input  logic [STATE_W-1:0] ra_cur,
    output state_ent_t         rd_cur,
    input  logic [STATE_W-1:0] ra_nxt,
    output state_ent_t         rd_nxt
);
    state_ent_t tbl [N_STATES];

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wdata;
    end

    assign rd_cur = tbl[ra_cur];
    assign rd_nxt = tbl[ra_nxt];
endmodule

// File: rtl/dfa_label_scan.sv
module dfa_label_scan
    import dfa_walk_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [TIDX_W-1:0]  waddr,
    input  trans_ent_t         wdata,
    input  logic [TIDX_W-1:0]  base,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CLASS_W-1:0] cls,
    output logic               hit,
    output logic [STATE_W-1:0] nxt
);
    trans_ent_t mem [N_TRANS];
    logic [MAX_LBL-1:0] slot_hit;
    logic [STATE_W-1:0] slot_nxt [MAX_LBL];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // All label slots of a state are compared in parallel.
    for (genvar i = 0; i < MAX_LBL; i++) begin : g_slot
        logic [TIDX_W-1:0] idx;
        trans_ent_t        ent;
        assign idx         = base + TIDX_W'(i);
        assign ent         = mem[idx];
        assign slot_hit[i] = (int'(cnt) > i) && (ent.cls == cls);
        assign slot_nxt[i] = ent.nxt;
    end

    // The lowest slot wins when a table holds duplicate labels.
    always_comb begin
        hit = 1'b0;
        nxt = '0;
        for (int i = MAX_LBL - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit = 1'b1;
                nxt = slot_nxt[i];
            end
        end
    end
endmodule

// File: rtl/dfa_walker.sv
module dfa_walker
    import dfa_walk_pkg::*;
#(
    parameter int CHAIN_MAX = 4,
    localparam int HOP_W    = $clog2(CHAIN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic              out_match,
    output logic [RULE_W-1:0] out_rule,
    output logic              err_chain,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [BYTE_W-1:0] ld_addr,
    input  logic [LD_W-1:0]   ld_data
);
    phase_t             phase;
    logic [STATE_W-1:0] cur;
    logic [CLASS_W-1:0] hold_cls;
    logic [HOP_W-1:0]   hops;

    logic               ld_ok, we_cls, we_st, we_tr;
    logic [CLASS_W-1:0] cls_in, look_cls;
    state_ent_t         st_cur, st_nxt;
    logic               hit, active, done, ovf, follow;
    logic [STATE_W-1:0] tnext, nxt;

    // Loads are honoured only when no byte is in flight or offered.
    assign ld_ok  = ld_en && (phase == PH_IDLE) && !in_valid;
    assign we_cls = ld_ok && (ld_sel == LD_CLASS);
    assign we_st  = ld_ok && (ld_sel == LD_STATE) && (int'(ld_addr) < N_STATES);
    assign we_tr  = ld_ok && (ld_sel == LD_TRANS) && (int'(ld_addr) < N_TRANS);

    dfa_class_map u_cmap (
        .clk   (clk),
        .we    (we_cls),
        .waddr (ld_addr),
        .wcls  (ld_data[CLASS_W-1:0]),
        .rbyte (in_byte),
        .rcls  (cls_in)
    );

    dfa_state_table u_stab (
        .clk    (clk),
        .we     (we_st),
        .waddr  (ld_addr[STATE_W-1:0]),
        .wdata  (state_ent_t'(ld_data)),
        .ra_cur (cur),
        .rd_cur (st_cur),
        .ra_nxt (nxt),
        .rd_nxt (st_nxt)
    );

    dfa_label_scan u_scan (
        .clk   (clk),
        .we    (we_tr),
        .waddr (ld_addr[TIDX_W-1:0]),
        .wdata (trans_ent_t'(ld_data[$bits(trans_ent_t)-1:0])),
        .base  (st_cur.base),
        .cnt   (st_cur.cnt),
        .cls   (look_cls),
        .hit   (hit),
        .nxt   (tnext)
    );

    assign in_ready = (phase == PH_IDLE);
    assign look_cls = (phase == PH_WALK) ? hold_cls : cls_in;
    assign active   = (in_valid && phase == PH_IDLE) || (phase == PH_WALK);

    always_comb begin
        done   = 1'b0;
        ovf    = 1'b0;
        follow = 1'b0;
        nxt    = cur;
        if (active) begin
            if (hit) begin
                done = 1'b1;
                nxt  = tnext;
            end else if (cur == '0) begin
                done = 1'b1;
                nxt  = '0;
            end else if (hops == HOP_W'(CHAIN_MAX)) begin
                done = 1'b1;
                ovf  = 1'b1;
                nxt  = '0;
            end else begin
                follow = 1'b1;
            end
        end
    end

    assign out_valid = done;
    assign out_match = done && !ovf && st_nxt.acc;
    assign out_rule  = out_match ? st_nxt.rule : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cur       <= '0;
            hold_cls  <= '0;
            hops      <= '0;
            err_chain <= 1'b0;
        end else if (done) begin
            phase <= PH_IDLE;
            cur   <= nxt;
            hops  <= '0;
            if (ovf) err_chain <= 1'b1;
        end else if (follow) begin
            phase    <= PH_WALK;
            cur      <= st_cur.dflt;
            hops     <= hops + 1'b1;
            hold_cls <= look_cls;
        end
    end
endmodule

// File: rtl/dfa_walker_chk.sv
module dfa_walker_chk
    import dfa_walk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_match,
    input logic [RULE_W-1:0] out_rule,
    input logic              err_chain
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !err_chain));

    assert_hit_keeps_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && out_valid) |=> in_ready);

    assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !out_valid) |=> !in_ready);

    assert_quiet_outputs_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_match && out_rule == '0));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_chain |=> err_chain);

    assert_err_drops_byte_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_chain) |-> $past(out_valid && !out_match));

    assert_out_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_valid || !in_ready));
endmodule

bind dfa_walker dfa_walker_chk u_chk (.*);

// File: tb/dfa_walker_bench.sv
module dfa_walker_bench;
    import dfa_walk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CHAIN      = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [BYTE_W-1:0] in_byte = '0;
    logic              out_valid, out_match, err_chain;
    logic [RULE_W-1:0] out_rule;
    logic              ld_en = 1'b0;
    logic [1:0]        ld_sel = '0;
    logic [BYTE_W-1:0] ld_addr = '0;
    logic [LD_W-1:0]   ld_data = '0;

    dfa_walker #(.CHAIN_MAX(CHAIN)) u_dfa_walker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_match(out_match),
        .out_rule(out_rule), .err_chain(err_chain), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic              m;
        logic [RULE_W-1:0] r;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0, n_fail = 0, n_sent = 0, n_out = 0;
    int   hs_cyc = 0, last_lat = -1;

    // Reference model: "abc" -> rule 5, "bb" -> rule 2, on the class-reduced stream.
    byte h0 = ".", h1 = ".", h2 = ".";
    bit  q_is_b = 0, z_trap = 0, trap_pending = 0;

    task automatic chk(string req, bit ok, int act, int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic byte norm(byte ch);
        if (ch == "a" || ch == "A") return "a";
        if (ch == "b" || (ch == "q" && q_is_b)) return "b";
        if (ch == "c") return "c";
        return ".";
    endfunction

    task automatic ref_push(byte ch);
        exp_t e;
        e = '0;
        if (trap_pending) begin
            trap_pending = 0;
            h0 = "."; h1 = "."; h2 = ".";
        end else if (z_trap && ch == "z") begin
            trap_pending = 1;
            h0 = "."; h1 = "."; h2 = ".";
        end else begin
            h0 = h1; h1 = h2; h2 = norm(ch);
            if (h0 == "a" && h1 == "b" && h2 == "c") e = '{m: 1'b1, r: 4'd5};
            else if (h1 == "b" && h2 == "b")         e = '{m: 1'b1, r: 4'd2};
        end
        expq.push_back(e);
    endtask

    // Monitor / scoreboard: samples away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (in_valid && in_ready) hs_cyc = cyc;
            if (out_valid) begin
                exp_t e;
                n_out++;
                last_lat = cyc - hs_cyc;
                if (expq.size() == 0) begin
                    chk("R9 unexpected out_valid", 1'b0, 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk("R6 match flag", out_match == e.m, int'(out_match), int'(e.m));
                    chk("R6 rule id", out_rule == e.r, int'(out_rule), int'(e.r));
                end
            end
        end
    end

    // Driver: called just after a rising edge; returns just after the handshake edge.
    task automatic send(byte ch);
        bit r;
        ref_push(ch);
        n_sent++;
        in_valid = 1'b1;
        in_byte  = ch;
        do begin
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
        end while (!r);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_str(string s);
        foreach (s[i]) send(s[i]);
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && expq.size() != 0; i++) begin
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic ld(logic [1:0] sel, int addr, logic [LD_W-1:0] data);
        ld_en   = 1'b1;
        ld_sel  = sel;
        ld_addr = BYTE_W'(addr);
        ld_data = data;
        @(posedge clk);
        #1;
        ld_en = 1'b0;
    endtask

    function automatic logic [LD_W-1:0] st(int base, int cnt, int dflt, bit acc, int rule);
        state_ent_t s;
        s.base = TIDX_W'(base);
        s.cnt  = CNT_W'(cnt);
        s.dflt = STATE_W'(dflt);
        s.acc  = acc;
        s.rule = RULE_W'(rule);
        return s;
    endfunction

    function automatic logic [LD_W-1:0] tr(int cls, int nxt);
        trans_ent_t t;
        t.cls = CLASS_W'(cls);
        t.nxt = STATE_W'(nxt);
        return LD_W'(t);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        expq.delete();
        h0 = "."; h1 = "."; h2 = ".";
        trap_pending = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 1'b0, cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 in_ready after reset", in_ready == 1'b1, int'(in_ready), 1);
        chk("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
        chk("R1 err_chain after reset", err_chain == 1'b0, int'(err_chain), 0);
        @(posedge clk);
        #1;

        // Class table: everything class 0, then a/A=1, b=2, c=3.
        for (int b = 0; b < N_BYTES; b++) ld(LD_CLASS, b, '0);
        ld(LD_CLASS, "a", 1); ld(LD_CLASS, "A", 1);
        ld(LD_CLASS, "b", 2); ld(LD_CLASS, "c", 3);
        // Transitions: S0{a->1,b->4} S1{b->2,a->1} S2{c->3,b->5} S4{b->5}
        ld(LD_TRANS, 0, tr(1, 1)); ld(LD_TRANS, 1, tr(2, 4));
        ld(LD_TRANS, 3, tr(2, 2)); ld(LD_TRANS, 4, tr(1, 1));
        ld(LD_TRANS, 5, tr(3, 3)); ld(LD_TRANS, 6, tr(2, 5));
        ld(LD_TRANS, 7, tr(2, 5));
        ld(LD_STATE, 0, st(0, 2, 0, 0, 0));
        ld(LD_STATE, 1, st(3, 2, 0, 0, 0));
        ld(LD_STATE, 2, st(5, 2, 0, 0, 0));
        ld(LD_STATE, 3, st(8, 0, 0, 1, 5));
        ld(LD_STATE, 4, st(7, 1, 0, 0, 0));
        ld(LD_STATE, 5, st(8, 0, 4, 1, 2));

        // R3: labelled hits resolve in the handshake cycle.
        send_str("abc");
        drain();
        chk("R3 hit latency", last_lat == 0, last_lat, 0);

        // R2: A shares class with a; x is class 0 and breaks the pattern.
        send_str("Abc");
        send_str("abxc");
        send_str("babcbbbac");
        drain();

        // R4: from S5, 'c' hops S5->S4->S0 before resolving.
        send_str("bb");
        send("c");
        chk("R4 in_ready low during chain", in_ready == 1'b0, int'(in_ready), 0);
        drain();
        chk("R4 two-hop latency", last_lat == 2, last_lat, 2);

        // R5: root miss consumed immediately, walker stays at root.
        send("x");
        drain();
        chk("R5 root miss latency", last_lat == 0, last_lat, 0);
        send_str("bb");
        drain();

        // R8: a load offered while a chain is being walked is ignored.
        send("a");
        send("c");
        ld(LD_CLASS, "q", 2);
        drain();
        send_str("qq");
        drain();
        ld(LD_CLASS, "q", 2);
        q_is_b = 1;
        send_str("qq");
        drain();

        // R7: self-looping default behind a new root label for 'z'.
        ld(LD_CLASS, "z", 4);
        ld(LD_TRANS, 2, tr(4, 6));
        ld(LD_STATE, 0, st(0, 3, 0, 0, 0));
        ld(LD_STATE, 6, st(8, 0, 6, 0, 0));
        z_trap = 1;
        send("z");
        send("a");
        drain();
        chk("R7 err_chain set", err_chain == 1'b1, int'(err_chain), 1);
        chk("R7 overflow latency", last_lat == CHAIN, last_lat, CHAIN);
        send_str("bb");
        drain();
        chk("R7 err_chain sticky", err_chain == 1'b1, int'(err_chain), 1);

        // R1: reset mid-pattern returns to state 0 and clears the error.
        send_str("ab");
        drain();
        do_reset();
        @(negedge clk);
        chk("R1 err cleared by reset", err_chain == 1'b0, int'(err_chain), 0);
        chk("R1 ready after reset", in_ready == 1'b1, int'(in_ready), 1);
        @(posedge clk);
        #1;
        send("c");
        drain();
        send_str("abc");
        drain();

        chk("R9 one output per byte", n_out == n_sent, n_out, n_sent);
        chk("R9 scoreboard empty", expq.size() == 0, expq.size(), 0);
        finish_run();
    end
endmodule